// File: doc/BRIEF.md
# Interrupt-capable GPIO controller

A general-purpose I/O unit for a host that sees it through a 16-bit register bus. It serves fifty pins: 32 bidirectional pins, each able to raise an interrupt, and 18 output-only pins. Every 32-bit control word is reached as two 16-bit halves. The low half sits at the word's byte offset and the high half at offset + 2. Pad drivers and pull resistors are outside the block. It drives their controls (`gpio_oe`, `pull_en`, `pull_up`) and receives the raw pad levels on `gpio_in`.

Each bidirectional pin passes through a two-flop synchronizer. Each pin then has its own condition logic. The trigger is either edge or level. A polarity bit picks rising edge or high level when set, and falling edge or low level when clear. A report bit picks latched (hold) status, which stays set until written with a 1, or transparent (through) status, which mirrors the live condition. The status bits are ANDed with per-pin enables and ORed into the single `irq` output.

The register bus is a plain single-cycle control path: a write commits on the clock edge where `reg_wr` is high, and read data appears on `reg_rdata` one edge after `reg_rd`. There is no back-pressure. Byte offsets (bit 0 of `reg_addr` is ignored): 0x00 direction, 0x04 pin data, 0x08 output-only data, 0x0C trigger type, 0x10 polarity, 0x14 report mode, 0x18 interrupt enable, 0x1C status, 0x20 pull enable, 0x24 pull-up select. Other offsets read as zero.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all pins are inputs (`gpio_oe` = 0), all enables and status bits are 0, `irq` is low, and all output and pull controls are 0.
- R2: Writing one 16-bit half (low at offset, high at offset + 2) changes only that half of the 32-bit word. The other half keeps its value.
- R3: In the direction word (0x00), a 1 makes the pin an output: `gpio_oe` bit is 1 and `gpio_out` drives the pin data word bit.
- R4: Reading the pin data word (0x04) returns the written value for output pins and the synchronized pad level for input pins.
- R5: The output-only pins take bits 0–17 of word 0x08 and drive `gpo_out`. Bits 18–31 read as 0 and ignore writes.
- R6: With trigger bit 0 (level), the condition is pin high when polarity bit is 1 and pin low when polarity bit is 0.
- R7: With trigger bit 1 (edge), the condition is a rising edge when polarity is 1 and a falling edge when polarity is 0. The status reaches `irq` three clock edges after the pad change.
- R8: With report bit 1 (hold), a status bit stays set after its condition ends. Writing 1 to it at 0x1C clears it, and writing 0 leaves it set.
- R9: With report bit 0 (through), a status bit follows the live condition, and writing 1 to it does not clear it while the condition holds.
- R10: `irq` is the OR over pins 0–31 of status AND enable (word 0x18). A pending status with its enable clear does not raise `irq`.
- R11: Words 0x20 and 0x24 drive `pull_en` and `pull_up` bit for bit.
- R12: A pin configured as an output never sets its status bit.
- R13: Read data appears on `reg_rdata` one edge after `reg_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, commits at the clock edge |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 6 | Byte offset; bit 1 selects the high half |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| gpio_in | input | 32 | Raw pad levels of pins 0–31 |
| gpio_out | output | 32 | Output levels of pins 0–31 |
| gpio_oe | output | 32 | Output enables of pins 0–31 |
| gpo_out | output | 18 | Output levels of pins 32–49 |
| pull_en | output | 32 | Pull resistor enables |
| pull_up | output | 32 | Pull direction, 1 = up |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes reach the pin and pull outputs on the edge that commits them. Read data is due one edge after the read strobe. A pad change reaches the synchronized readback after two edges and the status bit and `irq` after the third. The bench drives stimulus at falling edges and counts the exact rising edges for each result. It samples 1 ns after the last of them, so the one-cycle pulse of edge-through mode is caught in its only cycle, and it also checks that `irq` is still low one edge earlier.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned WORD_W = 2 * BUS_W;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned SEL_W  = ADDR_W - 2;

  typedef enum logic [SEL_W-1:0] {
    RG_DIR    = 4'd0,
    RG_DATA   = 4'd1,
    RG_OUTHI  = 4'd2,
    RG_TRIG   = 4'd3,
    RG_POL    = 4'd4,
    RG_HOLD   = 4'd5,
    RG_IEN    = 4'd6,
    RG_STAT   = 4'd7,
    RG_PULLEN = 4'd8,
    RG_PULLUP = 4'd9
  } reg_sel_e;

  // Replace one bus-wide half of a word, keep the other half.
  function automatic logic [WORD_W-1:0] merge_half(
    input logic [WORD_W-1:0] old_w,
    input logic              hi,
    input logic [BUS_W-1:0]  d
  );
    return hi ? {d, old_w[BUS_W-1:0]} : {old_w[WORD_W-1:BUS_W], d};
  endfunction
endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regbank.sv
module gpio_ctrl_regbank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_OUT = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  output logic [WORD_W-1:0]  dir_q,
  output logic [WORD_W-1:0]  data_q,
  output logic [NUM_OUT-1:0] outhi_q,
  output logic [WORD_W-1:0]  trig_q,
  output logic [WORD_W-1:0]  pol_q,
  output logic [WORD_W-1:0]  hold_q,
  output logic [WORD_W-1:0]  ien_q,
  output logic [WORD_W-1:0]  pullen_q,
  output logic [WORD_W-1:0]  pullup_q,
  output logic [WORD_W-1:0]  stat_clr
);
  reg_sel_e          sel;
  logic              hi;
  logic [WORD_W-1:0] outhi_w;
  logic              unused_addr_lsb;
  logic              unused_outhi;

  assign sel             = reg_sel_e'(addr[ADDR_W-1:2]);
  assign hi              = addr[1];
  assign unused_addr_lsb = addr[0];
  assign outhi_w         = merge_half(WORD_W'(outhi_q), hi, wdata);
  assign unused_outhi    = ^outhi_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      data_q   <= '0;
      outhi_q  <= '0;
      trig_q   <= '0;
      pol_q    <= '0;
      hold_q   <= '0;
      ien_q    <= '0;
      pullen_q <= '0;
      pullup_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RG_DIR:    dir_q    <= merge_half(dir_q, hi, wdata);
        RG_DATA:   data_q   <= merge_half(data_q, hi, wdata);
        RG_OUTHI:  outhi_q  <= outhi_w[NUM_OUT-1:0];
        RG_TRIG:   trig_q   <= merge_half(trig_q, hi, wdata);
        RG_POL:    pol_q    <= merge_half(pol_q, hi, wdata);
        RG_HOLD:   hold_q   <= merge_half(hold_q, hi, wdata);
        RG_IEN:    ien_q    <= merge_half(ien_q, hi, wdata);
        RG_PULLEN: pullen_q <= merge_half(pullen_q, hi, wdata);
        RG_PULLUP: pullup_q <= merge_half(pullup_q, hi, wdata);
        default: ;
      endcase
    end
  end

  // Write-one-to-clear pulse for the status word.
  always_comb begin
    stat_clr = '0;
    if (wr_en && sel == RG_STAT)
      stat_clr = merge_half('0, hi, wdata);
  end
endmodule

// File: rtl/gpio_ctrl_lane.sv
module gpio_ctrl_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic is_out,
  input  logic edge_mode,
  input  logic act_high,
  input  logic hold_mode,
  input  logic clr,
  output logic stat
);
  logic prev_q;
  logic active;
  logic hit;
  logic cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign active = act_high ? pin_s : ~pin_s;
  // Active now, inactive one cycle ago: rising for high, falling for low.
  assign hit    = active & (prev_q ^ act_high);
  assign cond   = ~is_out & (edge_mode ? hit : active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat <= 1'b0;
    else if (hold_mode) stat <= (stat & ~clr) | cond;
    else                stat <= cond;
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [BUS_W-1:0]   reg_wdata,
  output logic [BUS_W-1:0]   reg_rdata,
  input  logic [WORD_W-1:0]  gpio_in,
  output logic [WORD_W-1:0]  gpio_out,
  output logic [WORD_W-1:0]  gpio_oe,
  output logic [NUM_OUT-1:0] gpo_out,
  output logic [WORD_W-1:0]  pull_en,
  output logic [WORD_W-1:0]  pull_up,
  output logic               irq
);
  logic [WORD_W-1:0]  dir_q, data_q, trig_q, pol_q, hold_q, ien_q;
  logic [WORD_W-1:0]  pullen_q, pullup_q, stat_clr, stat_q, pin_s;
  logic [NUM_OUT-1:0] outhi_q;
  logic [WORD_W-1:0]  rd_word;
  logic [WORD_W-1:0]  pin_view;

  gpio_ctrl_regbank #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .dir_q    (dir_q),
    .data_q   (data_q),
    .outhi_q  (outhi_q),
    .trig_q   (trig_q),
    .pol_q    (pol_q),
    .hold_q   (hold_q),
    .ien_q    (ien_q),
    .pullen_q (pullen_q),
    .pullup_q (pullup_q),
    .stat_clr (stat_clr)
  );

  gpio_ctrl_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (gpio_in),
    .dout  (pin_s)
  );

  for (genvar g = 0; g < WORD_W; g++) begin : g_lane
    gpio_ctrl_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pin_s[g]),
      .is_out    (dir_q[g]),
      .edge_mode (trig_q[g]),
      .act_high  (pol_q[g]),
      .hold_mode (hold_q[g]),
      .clr       (stat_clr[g]),
      .stat      (stat_q[g])
    );
  end

  assign pin_view = (dir_q & data_q) | (~dir_q & pin_s);

  always_comb begin
    case (reg_sel_e'(reg_addr[ADDR_W-1:2]))
      RG_DIR:    rd_word = dir_q;
      RG_DATA:   rd_word = pin_view;
      RG_OUTHI:  rd_word = WORD_W'(outhi_q);
      RG_TRIG:   rd_word = trig_q;
      RG_POL:    rd_word = pol_q;
      RG_HOLD:   rd_word = hold_q;
      RG_IEN:    rd_word = ien_q;
      RG_STAT:   rd_word = stat_q;
      RG_PULLEN: rd_word = pullen_q;
      RG_PULLUP: rd_word = pullup_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= reg_addr[1] ? rd_word[WORD_W-1:BUS_W] : rd_word[BUS_W-1:0];
  end

  assign gpio_out = data_q;
  assign gpio_oe  = dir_q;
  assign gpo_out  = outhi_q;
  assign pull_en  = pullen_q;
  assign pull_up  = pullup_q;
  assign irq      = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker #(
  parameter int unsigned NUM_OUT = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [5:0]         reg_addr,
  input logic [15:0]        reg_wdata,
  input logic [15:0]        reg_rdata,
  input logic [31:0]        gpio_oe,
  input logic [NUM_OUT-1:0] gpo_out,
  input logic [31:0]        stat_q,
  input logic [31:0]        hold_q,
  input logic [31:0]        stat_clr,
  input logic               irq
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (gpio_oe == '0 && stat_q == '0 && !irq));

  // Direction high half written: high half follows, low half untouched (R2, R3).
  p_half_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[5:1] == 5'd1) |=>
      (gpio_oe[31:16] == $past(reg_wdata) && gpio_oe[15:0] == $past(gpio_oe[15:0])));

  p_outhi_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[5:1] == 5'd5) |=>
      (gpo_out[NUM_OUT-1:16] == $past(reg_wdata[NUM_OUT-17:0])));

  p_hold_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & hold_q & ~stat_clr)) == $past(stat_q & hold_q & ~stat_clr)));

  p_out_pin_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(gpio_oe)) == '0));

  p_read_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[5:1] == 5'd0) |=> (reg_rdata == $past(gpio_oe[15:0])));
endmodule

bind gpio_ctrl gpio_ctrl_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .gpio_oe   (gpio_oe),
  .gpo_out   (gpo_out),
  .stat_q    (stat_q),
  .hold_q    (hold_q),
  .stat_clr  (stat_clr),
  .irq       (irq)
);

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [31:0] gpio_in, gpio_out, gpio_oe, pull_en, pull_up;
  logic [17:0] gpo_out;
  logic        irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .gpo_out(gpo_out), .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
  );

  localparam logic [5:0] A_DIR = 6'h00, A_DATA = 6'h04, A_OUTHI = 6'h08,
    A_TRIG = 6'h0C, A_POL = 6'h10, A_HOLD = 6'h14, A_IEN = 6'h18,
    A_STAT = 6'h1C, A_PEN = 6'h20, A_PUP = 6'h24;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr32(input logic [5:0] a, input logic [31:0] d);
    wr(a, d[15:0]); wr(a + 6'd2, d[31:16]);
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rd32(input logic [5:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd(a, lo); rd(a + 6'd2, hi); d = {hi, lo};
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] h;
    int pins [4] = '{0, 7, 16, 31};
    logic [31:0] dirs [4] = '{32'h0000_FFFF, 32'hFFFF_0000, 32'h0F0F_F0F0, 32'h0};
    rst_n = 1'b0; gpio_in = '1;
    edges(3);
    rst_n = 1'b1;
    edges(4);
    // R1 reset state
    check("R1 oe", gpio_oe, 0); check("R1 irq", 32'(irq), 0);
    check("R1 out", gpio_out, 0); check("R1 gpo", 32'(gpo_out), 0);
    check("R1 pulls", pull_en | pull_up, 0);
    rd32(A_STAT, v); check("R1 stat", v, 0);
    rd32(A_IEN, v);  check("R1 ien", v, 0);

    // R2 half access
    wr(A_DIR, 16'h00FF); wr(A_DIR + 6'd2, 16'hA500);
    check("R2 both halves", gpio_oe, 32'hA500_00FF);
    wr(A_DIR, 16'h1234);
    check("R2 low only", gpio_oe, 32'hA500_1234);
    rd(A_DIR + 6'd2, h); check("R2 high read", 32'(h), 32'hA500);

    // R3 / R4 direction and data over several patterns
    wr32(A_DATA, 32'h1234_ABCD);
    check("R3 out", gpio_out, 32'h1234_ABCD);
    foreach (dirs[k]) begin
      wr32(A_DIR, dirs[k]);
      check("R3 oe", gpio_oe, dirs[k]);
      gpio_in = 32'hCAFE_5555 ^ dirs[k];
      edges(3);
      rd32(A_DATA, v);
      check("R4 readback", v, (dirs[k] & 32'h1234_ABCD) | (~dirs[k] & (32'hCAFE_5555 ^ dirs[k])));
    end
    wr32(A_DIR, 0);

    // R5 output-only pins
    wr(A_OUTHI, 16'hBEEF); wr(A_OUTHI + 6'd2, 16'hFFFF);
    check("R5 gpo", 32'(gpo_out), 32'h3_BEEF);
    rd(A_OUTHI + 6'd2, h); check("R5 upper read", 32'(h), 32'h0003);

    // R11 pulls
    wr32(A_PEN, 32'h8001_0F0F); wr32(A_PUP, 32'h00FF_F00F);
    check("R11 en", pull_en, 32'h8001_0F0F); check("R11 up", pull_up, 32'h00FF_F00F);

    // R13 unmapped read
    rd(6'h30, h); check("R13 unmapped", 32'(h), 0);

    // R6..R9 sweep: every mode on several pins
    for (int m = 0; m < 8; m++) begin
      foreach (pins[q]) begin
        automatic int p = pins[q];
        automatic logic trig = m[0], pol = m[1], hold = m[2];
        wr32(A_TRIG, trig ? '1 : '0);
        wr32(A_POL,  pol  ? '1 : '0);
        wr32(A_HOLD, hold ? '1 : '0);
        wr32(A_IEN, 32'h1 << p);
        gpio_in = pol ? '0 : '1;
        edges(6);
        wr32(A_STAT, '1);
        edges(1);
        check(trig ? "R7 idle" : "R6 idle", 32'(irq), 0);
        @(negedge clk); gpio_in[p] = pol;
        edges(2);
        check("R7 latency early", 32'(irq), 0);
        edges(1);
        check(trig ? "R7 event" : "R6 event", 32'(irq), 1);
        edges(1);
        check(hold ? "R8 held" : "R9 follows", 32'(irq), (trig && !hold) ? 0 : 1);
        if (hold) begin
          rd32(A_STAT, v); check("R8 stat word", v, 32'h1 << p);
        end
        if (!hold && !trig) begin
          wr32(A_STAT, '1);
          check("R9 clear ignored", 32'(irq), 1);
        end
        @(negedge clk); gpio_in[p] = ~pol;
        edges(3);
        check(hold ? "R8 after end" : "R9 after end", 32'(irq), 32'(hold));
        if (hold) begin
          wr32(A_STAT, ~(32'h1 << p));
          check("R8 zero write", 32'(irq), 1);
          wr32(A_STAT, 32'h1 << p);
          check("R8 w1c", 32'(irq), 0);
        end
      end
    end

    // R10 enable gating: level, high, through
    wr32(A_TRIG, 0); wr32(A_POL, '1); wr32(A_HOLD, 0); wr32(A_IEN, 0);
    gpio_in = 32'h0000_0008;
    edges(4);
    check("R10 gated", 32'(irq), 0);
    rd32(A_STAT, v); check("R10 pending", v, 32'h0000_0008);
    wr32(A_IEN, 32'h0000_0008);
    check("R10 enabled", 32'(irq), 1);

    // R12 output pin raises nothing
    wr32(A_HOLD, '1);
    wr32(A_DIR, 32'h0000_0008);
    wr32(A_STAT, '1);
    edges(4);
    check("R12 irq", 32'(irq), 0);
    rd32(A_STAT, v); check("R12 stat", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule